// File: doc/BRIEF.md
# Fail-First Vector Length Truncator

This block sits beside a vector load/store sequencer. The sequencer issues the accesses of one vector operation one element at a time, in element order. For each element it hands the block three things: the element index, a flag saying the access would fault, and the returned or stored data. The block decides whether each element retires and whether the base-register update for that element may be written back. It also decides whether an exception must be raised, and it fixes the final vector length. The memory access itself happens elsewhere.

Two truncation modes can be enabled per operation, separately or together. In fault-first mode, a fault on the leading element behaves as an ordinary scalar fault. A fault on any later element quietly ends the vector just before that element. The sequencer may also ask to end the vector early at any later element for reasons of its own. In data-dependent mode, each element's data is compared as a signed value against zero. This builds a 4-bit condition field, and one bit of that field, optionally inverted, decides whether the vector stops at this element. An inclusive setting decides whether the stopping element itself still belongs to the vector. The condition field can optionally be sent on for a register-file write.

The settings are captured when an operation starts. Results come out of registers one cycle after each element is presented.

Top module: `ff_vl_truncator`

## Requirements
- R1: After reset, `busy`, `done`, `exc_req`, `data_commit`, `addr_commit`, `cancel` and `cr_wr` are 0 and `vl_out` is 0.
- R2: A fault on element 0, or a fault on any element while fault-first mode is off, pulses `exc_req` one cycle after the element. `data_commit`, `addr_commit` and `done` stay low, and `busy` drops.
- R3: With fault-first mode on, a fault on element i > 0 pulses `cancel` with no exception and no commit. In the same cycle `done` pulses and `vl_out` = i.
- R4: With fault-first mode on, an early-stop request on element i > 0 acts exactly like a fault under R3. On element 0 the request is ignored and the element retires normally, so the length can never reach 0 by this path.
- R5: The condition field is {LT, GT, EQ, SO} at bit positions 3, 2, 1 and 0. It comes from a signed comparison of the data with zero, and SO is always 0. It appears on `cr_field` with `cr_wr` high and `cr_idx` = element index only when data-dependent mode and the write-enable setting are both on.
- R6: In data-dependent mode, `cfg_bit` = k selects `cr_field[k]`. The element fails the test when that bit XOR `cfg_inv` is 1. So with inv = 0 a set bit stops the vector, and with inv = 1 a clear bit stops it.
- R7: On a failed test with the inclusive setting on, the element commits data and address. `done` pulses with `vl_out` = i + 1.
- R8: On a failed test with the inclusive setting off, `cancel` pulses, `addr_commit` stays 0 and `vl_out` = i with `done`. `data_commit` is 0 for a store and 1 for a load.
- R9: An element that passes every check pulses `data_commit` and `addr_commit`. When it is element `cfg_vl`-1, `done` pulses with `vl_out` = `cfg_vl` and `busy` drops.
- R10: While no operation is active, presented elements produce no commit, cancel, exception, condition write or done.
- R11: Starting with `cfg_vl` = 0 pulses `done` with `vl_out` = 0 on the next cycle and leaves `busy` low.
- R12: With data-dependent mode off, the data never stops the vector and `cr_wr` stays 0, even with the write-enable setting on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation and capture the settings |
| cfg_vl | input | VL_W | Starting vector length |
| cfg_ff | input | 1 | Fault-first mode enable |
| cfg_dd | input | 1 | Data-dependent mode enable |
| cfg_incl | input | 1 | Failing element stays inside the vector |
| cfg_inv | input | 1 | Invert the tested condition bit |
| cfg_bit | input | 2 | Condition bit select |
| cfg_crwe | input | 1 | Forward the condition field for writing |
| cfg_store | input | 1 | Operation is a store |
| elem_valid | input | 1 | Element presented this cycle |
| elem_idx | input | VL_W | Element index |
| elem_fault | input | 1 | Access would fault |
| elem_stop | input | 1 | Implementation early-stop request |
| elem_data | input | DATA_W | Loaded or stored data |
| busy | output | 1 | Operation in progress |
| data_commit | output | 1 | Element data retires (memory or register write) |
| addr_commit | output | 1 | Base-register update may be written |
| cancel | output | 1 | Element left outside the final vector |
| exc_req | output | 1 | Raise the element's exception |
| cr_wr | output | 1 | Condition field write strobe |
| cr_field | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_idx | output | VL_W | Element index for the condition write |
| done | output | 1 | Final length valid |
| vl_out | output | VL_W | Final vector length |

## Verification
The bench builds the block with DATA_W = 16 and VL_W = 4. With a 16-bit data path, the signed boundary values 16'h8000 and 16'h7FFF, the value -3 and zero can be written directly, which covers all three condition-field outcomes and the LT-based test with inversion. A 4-bit length keeps every operation to a few elements, so fault positions at the first, a middle and the last element can be reached in short directed sequences.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

    // Positions inside the 4-bit condition field.
    localparam int CR_SO = 0;
    localparam int CR_EQ = 1;
    localparam int CR_GT = 2;
    localparam int CR_LT = 3;
    localparam int CR_W  = 4;

    // Settings captured at the start of an operation.
    typedef struct packed {
        logic       ff;
        logic       dd;
        logic       incl;
        logic       inv;
        logic [1:0] sel;
        logic       crwe;
        logic       store;
    } ffvl_mode_t;

    // Per-element outcome produced by the decoder.
    typedef struct packed {
        logic data_ok;
        logic addr_ok;
        logic drop;
        logic trap;
        logic finish;
        logic cr_we;
    } ffvl_verdict_t;

endpackage

// File: rtl/ffvl_cond_gen.sv
module ffvl_cond_gen
    import ffvl_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] data,
    output logic [CR_W-1:0]   cr
);

    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg        = data[DATA_W-1];
        is_zero       = (data == '0);
        cr            = '0;
        cr[CR_LT]     = is_neg;
        cr[CR_EQ]     = is_zero;
        cr[CR_GT]     = !is_neg && !is_zero;
        cr[CR_SO]     = 1'b0;
    end

endmodule

// File: rtl/ffvl_elem_judge.sv
module ffvl_elem_judge
    import ffvl_pkg::*;
#(
    parameter int VL_W   = 7,
    parameter int DATA_W = 64
) (
    input  ffvl_mode_t        mode,
    input  logic [VL_W-1:0]   lim,
    input  logic [VL_W-1:0]   idx,
    input  logic              fault,
    input  logic              stop_req,
    input  logic [DATA_W-1:0] data,
    output ffvl_verdict_t     verdict,
    output logic [VL_W-1:0]   new_vl,
    output logic [CR_W-1:0]   cr
);

    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    logic first;
    logic hit;
    logic last;

    ffvl_cond_gen #(.DATA_W(DATA_W)) u_cond (
        .data (data),
        .cr   (cr)
    );

    always_comb begin
        verdict = '0;
        new_vl  = lim;
        first   = (idx == '0);
        last    = (idx == lim - ONE);
        hit     = mode.dd && (cr[mode.sel] ^ mode.inv);

        if (fault) begin
            if (first || !mode.ff) begin
                verdict.trap = 1'b1;
            end else begin
                verdict.drop   = 1'b1;
                verdict.finish = 1'b1;
                new_vl         = idx;
            end
        end else if (stop_req && mode.ff && !first) begin
            verdict.drop   = 1'b1;
            verdict.finish = 1'b1;
            new_vl         = idx;
        end else begin
            verdict.cr_we = mode.dd && mode.crwe;
            if (hit) begin
                verdict.finish = 1'b1;
                if (mode.incl) begin
                    verdict.data_ok = 1'b1;
                    verdict.addr_ok = 1'b1;
                    new_vl          = idx + ONE;
                end else begin
                    verdict.data_ok = !mode.store;
                    verdict.drop    = 1'b1;
                    new_vl          = idx;
                end
            end else begin
                verdict.data_ok = 1'b1;
                verdict.addr_ok = 1'b1;
                if (last) begin
                    verdict.finish = 1'b1;
                    new_vl         = lim;
                end
            end
        end
    end

endmodule

// File: rtl/ff_vl_truncator.sv
module ff_vl_truncator
    import ffvl_pkg::*;
#(
    parameter int VL_W   = 7,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   cfg_vl,
    input  logic              cfg_ff,
    input  logic              cfg_dd,
    input  logic              cfg_incl,
    input  logic              cfg_inv,
    input  logic [1:0]        cfg_bit,
    input  logic              cfg_crwe,
    input  logic              cfg_store,
    input  logic              elem_valid,
    input  logic [VL_W-1:0]   elem_idx,
    input  logic              elem_fault,
    input  logic              elem_stop,
    input  logic [DATA_W-1:0] elem_data,
    output logic              busy,
    output logic              data_commit,
    output logic              addr_commit,
    output logic              cancel,
    output logic              exc_req,
    output logic              cr_wr,
    output logic [3:0]        cr_field,
    output logic [VL_W-1:0]   cr_idx,
    output logic              done,
    output logic [VL_W-1:0]   vl_out
);

    typedef struct packed {
        logic            busy;
        ffvl_mode_t      mode;
        logic [VL_W-1:0] lim;
        logic            data_commit;
        logic            addr_commit;
        logic            cancel;
        logic            exc;
        logic            cr_wr;
        logic [CR_W-1:0] cr;
        logic [VL_W-1:0] cr_idx;
        logic            done;
        logic [VL_W-1:0] vl;
    } state_t;

    state_t        st_d;
    state_t        st_q;
    ffvl_mode_t    cfg_mode;
    ffvl_verdict_t verdict;
    logic [VL_W-1:0] judged_vl;
    logic [CR_W-1:0] judged_cr;

    always_comb begin
        cfg_mode       = '0;
        cfg_mode.ff    = cfg_ff;
        cfg_mode.dd    = cfg_dd;
        cfg_mode.incl  = cfg_incl;
        cfg_mode.inv   = cfg_inv;
        cfg_mode.sel   = cfg_bit;
        cfg_mode.crwe  = cfg_crwe;
        cfg_mode.store = cfg_store;
    end

    ffvl_elem_judge #(.VL_W(VL_W), .DATA_W(DATA_W)) u_judge (
        .mode     (st_q.mode),
        .lim      (st_q.lim),
        .idx      (elem_idx),
        .fault    (elem_fault),
        .stop_req (elem_stop),
        .data     (elem_data),
        .verdict  (verdict),
        .new_vl   (judged_vl),
        .cr       (judged_cr)
    );

    always_comb begin
        st_d             = st_q;
        st_d.data_commit = 1'b0;
        st_d.addr_commit = 1'b0;
        st_d.cancel      = 1'b0;
        st_d.exc         = 1'b0;
        st_d.cr_wr       = 1'b0;
        st_d.done        = 1'b0;

        if (start) begin
            st_d.mode = cfg_mode;
            st_d.lim  = cfg_vl;
            st_d.vl   = cfg_vl;
            st_d.busy = (cfg_vl != '0);
            st_d.done = (cfg_vl == '0);
        end else if (st_q.busy && elem_valid) begin
            st_d.data_commit = verdict.data_ok;
            st_d.addr_commit = verdict.addr_ok;
            st_d.cancel      = verdict.drop;
            st_d.exc         = verdict.trap;
            st_d.cr_wr       = verdict.cr_we;
            if (verdict.cr_we) begin
                st_d.cr     = judged_cr;
                st_d.cr_idx = elem_idx;
            end
            if (verdict.finish) begin
                st_d.done = 1'b1;
                st_d.vl   = judged_vl;
                st_d.busy = 1'b0;
            end
            if (verdict.trap) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign data_commit = st_q.data_commit;
    assign addr_commit = st_q.addr_commit;
    assign cancel      = st_q.cancel;
    assign exc_req     = st_q.exc;
    assign cr_wr       = st_q.cr_wr;
    assign cr_field    = st_q.cr;
    assign cr_idx      = st_q.cr_idx;
    assign done        = st_q.done;
    assign vl_out      = st_q.vl;

endmodule

// File: rtl/ff_vl_truncator_chk.sv
module ff_vl_truncator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       data_commit,
    input logic       addr_commit,
    input logic       cancel,
    input logic       exc_req,
    input logic       cr_wr,
    input logic [3:0] cr_field,
    input logic       done
);

    // R2: an exception never travels with a commit or a final length
    assert_exc_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (!data_commit && !addr_commit && !done && !busy));

    // R2: exception and completion are exclusive
    assert_end_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_req, done}));

    // R3: a cancelled element never updates the base register
    assert_cancel_noaddr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |-> !addr_commit);

    // R5: condition field has SO clear and exactly one of LT/GT/EQ
    assert_cr_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr |-> (!cr_field[0] && ($countones(cr_field[3:1]) == 1)));

    // R8: the address update only commits with the element data
    assert_addr_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_commit |-> data_commit);

    // R9: completion leaves the block idle
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: an idle block with no start produces no element activity
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !(data_commit || addr_commit || cancel || exc_req || cr_wr || done));

endmodule

bind ff_vl_truncator ff_vl_truncator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .data_commit (data_commit),
    .addr_commit (addr_commit),
    .cancel      (cancel),
    .exc_req     (exc_req),
    .cr_wr       (cr_wr),
    .cr_field    (cr_field),
    .done        (done)
);

// File: tb/ff_vl_truncator_bench.sv
`timescale 1ns/1ps
module ff_vl_truncator_bench;

    localparam int VL_W   = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VL_W-1:0]   cfg_vl = '0;
    logic              cfg_ff = 1'b0;
    logic              cfg_dd = 1'b0;
    logic              cfg_incl = 1'b0;
    logic              cfg_inv = 1'b0;
    logic [1:0]        cfg_bit = '0;
    logic              cfg_crwe = 1'b0;
    logic              cfg_store = 1'b0;
    logic              elem_valid = 1'b0;
    logic [VL_W-1:0]   elem_idx = '0;
    logic              elem_fault = 1'b0;
    logic              elem_stop = 1'b0;
    logic [DATA_W-1:0] elem_data = '0;
    logic              busy;
    logic              data_commit;
    logic              addr_commit;
    logic              cancel;
    logic              exc_req;
    logic              cr_wr;
    logic [3:0]        cr_field;
    logic [VL_W-1:0]   cr_idx;
    logic              done;
    logic [VL_W-1:0]   vl_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ff_vl_truncator #(.VL_W(VL_W), .DATA_W(DATA_W)) u_ff_vl_truncator (
        .clk (clk), .rst_n (rst_n), .start (start), .cfg_vl (cfg_vl),
        .cfg_ff (cfg_ff), .cfg_dd (cfg_dd), .cfg_incl (cfg_incl),
        .cfg_inv (cfg_inv), .cfg_bit (cfg_bit), .cfg_crwe (cfg_crwe),
        .cfg_store (cfg_store), .elem_valid (elem_valid), .elem_idx (elem_idx),
        .elem_fault (elem_fault), .elem_stop (elem_stop), .elem_data (elem_data),
        .busy (busy), .data_commit (data_commit), .addr_commit (addr_commit),
        .cancel (cancel), .exc_req (exc_req), .cr_wr (cr_wr),
        .cr_field (cr_field), .cr_idx (cr_idx), .done (done), .vl_out (vl_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives are applied 1 ns after a rising edge; results sampled 1 ns after the next one.
    task automatic begin_op(input int vl, input bit ff, input bit dd, input bit incl,
                            input bit inv, input int sel, input bit crwe, input bit store);
        start     = 1'b1;
        cfg_vl    = VL_W'(vl);
        cfg_ff    = ff;
        cfg_dd    = dd;
        cfg_incl  = incl;
        cfg_inv   = inv;
        cfg_bit   = 2'(sel);
        cfg_crwe  = crwe;
        cfg_store = store;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic elem(input int idx, input bit fault, input bit stp, input int data);
        elem_valid = 1'b1;
        elem_idx   = VL_W'(idx);
        elem_fault = fault;
        elem_stop  = stp;
        elem_data  = DATA_W'(data);
        @(posedge clk); #1;
        elem_valid = 1'b0;
        elem_fault = 1'b0;
        elem_stop  = 1'b0;
    endtask

    task automatic expect_out(input string req, input bit dc, input bit ac, input bit cn,
                              input bit ex, input bit dn);
        check(req, "data_commit", int'(data_commit), int'(dc));
        check(req, "addr_commit", int'(addr_commit), int'(ac));
        check(req, "cancel",      int'(cancel),      int'(cn));
        check(req, "exc_req",     int'(exc_req),     int'(ex));
        check(req, "done",        int'(done),        int'(dn));
    endtask

    task automatic t_reset();
        check("R1", "busy",   int'(busy),   0);
        check("R1", "vl_out", int'(vl_out), 0);
        check("R1", "cr_wr",  int'(cr_wr),  0);
        expect_out("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_all_pass();
        begin_op(4, 0, 0, 0, 0, 0, 0, 1);
        check("R9", "busy after start", int'(busy), 1);
        for (int i = 0; i < 3; i++) begin
            elem(i, 0, 0, 16'h0000);
            expect_out("R9", 1, 1, 0, 0, 0);
        end
        elem(3, 0, 0, 16'h0010);
        expect_out("R9", 1, 1, 0, 0, 1);
        check("R9", "vl_out", int'(vl_out), 4);
        check("R9", "busy",   int'(busy),   0);
        elem(0, 0, 0, 0);
        expect_out("R10", 0, 0, 0, 0, 0);
    endtask

    task automatic t_fault_first_elem();
        begin_op(4, 1, 0, 0, 0, 0, 0, 0);
        elem(0, 1, 0, 0);
        expect_out("R2", 0, 0, 0, 1, 0);
        check("R2", "busy", int'(busy), 0);
        elem(1, 0, 0, 0);
        expect_out("R10", 0, 0, 0, 0, 0);
    endtask

    task automatic t_fault_without_ff();
        begin_op(4, 0, 0, 0, 0, 0, 0, 0);
        elem(0, 0, 0, 1);
        expect_out("R2", 1, 1, 0, 0, 0);
        elem(1, 1, 0, 1);
        expect_out("R2", 0, 0, 0, 1, 0);
    endtask

    task automatic t_fault_late();
        begin_op(8, 1, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) elem(i, 0, 0, 5);
        elem(3, 1, 0, 5);
        expect_out("R3", 0, 0, 1, 0, 1);
        check("R3", "vl_out", int'(vl_out), 3);
    endtask

    task automatic t_early_stop();
        begin_op(6, 1, 0, 0, 0, 0, 0, 1);
        elem(0, 0, 1, 9);
        expect_out("R4", 1, 1, 0, 0, 0);
        check("R4", "busy", int'(busy), 1);
        elem(1, 0, 1, 9);
        expect_out("R4", 0, 0, 1, 0, 1);
        check("R4", "vl_out", int'(vl_out), 1);
    endtask

    task automatic t_dd_inclusive();
        begin_op(8, 0, 1, 1, 0, 1, 1, 1);
        elem(0, 0, 0, 5);
        check("R5", "cr_wr", int'(cr_wr), 1);
        check("R5", "cr_field gt", int'(cr_field), 4'b0100);
        check("R5", "cr_idx", int'(cr_idx), 0);
        expect_out("R6", 1, 1, 0, 0, 0);
        elem(1, 0, 0, 16'hFFFD);
        check("R5", "cr_field lt", int'(cr_field), 4'b1000);
        check("R5", "cr_idx", int'(cr_idx), 1);
        elem(2, 0, 0, 0);
        check("R5", "cr_field eq", int'(cr_field), 4'b0010);
        expect_out("R7", 1, 1, 0, 0, 1);
        check("R7", "vl_out", int'(vl_out), 3);
    endtask

    task automatic t_dd_exclusive_store();
        begin_op(8, 0, 1, 0, 0, 1, 0, 1);
        elem(0, 0, 0, 7);
        check("R5", "cr_wr without enable", int'(cr_wr), 0);
        expect_out("R6", 1, 1, 0, 0, 0);
        elem(1, 0, 0, 0);
        expect_out("R8", 0, 0, 1, 0, 1);
        check("R8", "vl_out", int'(vl_out), 1);
    endtask

    task automatic t_dd_exclusive_load();
        begin_op(8, 0, 1, 0, 0, 1, 0, 0);
        elem(0, 0, 0, 0);
        expect_out("R8", 1, 0, 1, 0, 1);
        check("R8", "vl_out", int'(vl_out), 0);
    endtask

    task automatic t_dd_inverted();
        begin_op(8, 0, 1, 1, 1, 3, 1, 0);
        elem(0, 0, 0, 16'h8000);
        expect_out("R6", 1, 1, 0, 0, 0);
        check("R6", "cr_field", int'(cr_field), 4'b1000);
        elem(1, 0, 0, 16'h7FFF);
        check("R6", "cr_field", int'(cr_field), 4'b0100);
        expect_out("R6", 1, 1, 0, 0, 1);
        check("R6", "vl_out", int'(vl_out), 2);
    endtask

    task automatic t_zero_length();
        begin_op(0, 1, 1, 0, 0, 0, 0, 0);
        check("R11", "done",   int'(done),   1);
        check("R11", "vl_out", int'(vl_out), 0);
        check("R11", "busy",   int'(busy),   0);
    endtask

    task automatic t_dd_off();
        begin_op(3, 0, 0, 0, 0, 1, 1, 0);
        elem(0, 0, 0, 0);
        check("R12", "cr_wr", int'(cr_wr), 0);
        expect_out("R12", 1, 1, 0, 0, 0);
        check("R12", "busy", int'(busy), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_all_pass();
        t_fault_first_elem();
        t_fault_without_ff();
        t_fault_late();
        t_early_stop();
        t_dd_inclusive();
        t_dd_exclusive_store();
        t_dd_exclusive_load();
        t_dd_inverted();
        t_zero_length();
        t_dd_off();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule